// File: doc/BRIEF.md
# Clamp-Referenced Digital Gain Stage

This block scales a stream of 10-bit video samples by a programmable fixed-point gain. The gain acts on the distance of each sample from a programmable black level, and that level is then added back. A sample sitting exactly on the black level therefore leaves the block unchanged, whatever the gain. Results are rounded, saturated to the 10-bit range and presented two clocks after the matching input strobe.

A byte-wide write port sets the gain and the black level. The gain is loaded as two bytes. Writing the low byte only stages its value. Writing the high byte moves the full 12-bit code into a holding register. The clamp code is held in the same way. A held value moves into the working set on any clock while the gating condition allows it. With the gating mode on, transfers happen only while the blanking input is high, so gain and level never change inside the active picture. With the mode off, a held value moves across on the clock after it is written.

Top module: `clamp_gain_stage`

## Requirements
- R1: After reset `out_valid` is 0 and `out_sample` is 0. The working gain is 2.0 (code 0x400) and the clamp code is 0, so a sample x gives min(2x, 1023).
- R2: The output equals round(gain × (sample − level)) + level. The gain code is 3.9 unsigned fixed point (value = code / 512). Rounding is to nearest, with exact halves rounded towards plus infinity.
- R3: A result below 0 is output as 0. A result above 1023 is output as 1023. The output never wraps.
- R4: `out_valid` equals `in_valid` from two clocks earlier. `out_sample` changes only on cycles when `out_valid` is high.
- R5: A write to address 0 (gain low byte, `wr_data[7:0]` = gain bits 7:0) alone leaves the gain used for later samples unchanged.
- R6: A write to address 1 (`wr_data[3:0]` = gain bits 11:8) commits the 12-bit gain made of these bits and the last staged low byte.
- R7: A write to address 2 sets the clamp code from `wr_data[6:0]`. The black level is that code times 16.
- R8: With a gain code of 0x200 (1.0), every sample is output unchanged.
- R9: A sample equal to the black level is output unchanged for any gain.
- R10: While `sync_gate_en` is 1, written gain or clamp values move into the working set only on clocks when `blank_in` is 1. While `sync_gate_en` is 0, they move across on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 10 | Input sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 gain low byte, 1 gain high bits, 2 clamp code |
| wr_data | input | 8 | Write data |
| sync_gate_en | input | 1 | Limit working-set updates to blanking |
| blank_in | input | 1 | High outside active video |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 10 | Scaled, rounded, saturated sample |

## Verification
Random samples, gains and clamp codes are compared with a bench model of the rounded, saturated equation. This shows whether the sign and rounding of the product are right across the whole range. Directed cases then separate the other behaviours:
- Unity gain checks the fractional scaling.
- Samples placed on the black level check that the level is re-added.
- Extreme gains check saturation at both ends.
- Exact half products check the rounding direction.
- A lone low-byte write checks that staging alone has no effect.
- Writes made inside active video with gating on show whether updates wait for blanking.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_GAIN_LO = 2'd0,
    ADDR_GAIN_HI = 2'd1,
    ADDR_CLAMP   = 2'd2
  } cgs_addr_e;
endpackage

// File: rtl/cgs_regs.sv
module cgs_regs
  import cgs_pkg::*;
#(
  parameter int GW  = 12,
  parameter int GF  = 9,
  parameter int CW  = 7,
  parameter int CSH = 4,
  localparam int CLW = CW + CSH,
  localparam int HIW = GW - 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sync_gate_en,
  input  logic              blank_in,
  output logic [GW-1:0]     gain_act,
  output logic [CLW-1:0]    clamp_lvl
);
  localparam logic [GW-1:0] GAIN_RST = GW'(2) << GF;

  logic [7:0]    lo_stage;
  logic [GW-1:0] gain_hold;
  logic [CW-1:0] clamp_hold;
  logic [CW-1:0] clamp_act;
  logic          xfer_ok;

  assign xfer_ok = !sync_gate_en || blank_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage   <= '0;
      gain_hold  <= GAIN_RST;
      clamp_hold <= '0;
    end else if (wr_en) begin
      case (cgs_addr_e'(wr_addr))
        ADDR_GAIN_LO: lo_stage   <= wr_data;
        ADDR_GAIN_HI: gain_hold  <= {wr_data[HIW-1:0], lo_stage};
        ADDR_CLAMP:   clamp_hold <= wr_data[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_act  <= GAIN_RST;
      clamp_act <= '0;
    end else if (xfer_ok) begin
      gain_act  <= gain_hold;
      clamp_act <= clamp_hold;
    end
  end

  assign clamp_lvl = {clamp_act, {CSH{1'b0}}};
endmodule

// File: rtl/cgs_datapath.sv
module cgs_datapath #(
  parameter int DW  = 10,
  parameter int GW  = 12,
  parameter int GF  = 9,
  parameter int CLW = 11,
  localparam int DFW = CLW + 1,
  localparam int PW  = DFW + GW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_sample,
  input  logic [GW-1:0]  gain,
  input  logic [CLW-1:0] clamp_lvl,
  output logic           out_valid,
  output logic [DW-1:0]  out_sample
);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GF - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << DW) - 1);

  logic signed [DFW-1:0] diff;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  p1;
  logic [CLW-1:0]        c1;
  logic                  v1;
  logic signed [PW-1:0]  rnd;
  logic signed [PW-1:0]  sum;
  logic [DW-1:0]         sat;

  // Stage 1: offset from the black level, then scale
  always_comb begin
    diff = $signed(DFW'(in_sample)) - $signed({1'b0, clamp_lvl});
    prod = PW'(diff) * $signed(PW'(gain));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      p1 <= '0;
      c1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        p1 <= prod;
        c1 <= clamp_lvl;
      end
    end
  end

  // Stage 2: round, restore the level, saturate
  always_comb begin
    rnd = (p1 + HALF) >>> GF;
    sum = rnd + $signed(PW'(c1));
    if (sum < 0)         sat = '0;
    else if (sum > MAXV) sat = '1;
    else                 sat = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_sample <= sat;
    end
  end
endmodule

// File: rtl/clamp_gain_stage.sv
module clamp_gain_stage
  import cgs_pkg::*;
#(
  parameter int DW  = 10,
  parameter int GW  = 12,
  parameter int GF  = 9,
  parameter int CW  = 7,
  parameter int CSH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_sample,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sync_gate_en,
  input  logic              blank_in,
  output logic              out_valid,
  output logic [DW-1:0]     out_sample
);
  localparam int CLW = CW + CSH;

  logic [GW-1:0]  gain_act;
  logic [CLW-1:0] clamp_lvl;

  cgs_regs #(.GW(GW), .GF(GF), .CW(CW), .CSH(CSH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_gate_en(sync_gate_en), .blank_in(blank_in),
    .gain_act(gain_act), .clamp_lvl(clamp_lvl)
  );

  cgs_datapath #(.DW(DW), .GW(GW), .GF(GF), .CLW(CLW)) u_dp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .gain(gain_act), .clamp_lvl(clamp_lvl),
    .out_valid(out_valid), .out_sample(out_sample)
  );
endmodule

// File: rtl/cgs_checker.sv
module cgs_checker #(
  parameter int DW  = 10,
  parameter int GW  = 12,
  parameter int GF  = 9,
  parameter int CLW = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [DW-1:0]  in_sample,
  input logic           sync_gate_en,
  input logic           blank_in,
  input logic           out_valid,
  input logic [DW-1:0]  out_sample,
  input logic [GW-1:0]  gain_act,
  input logic [CLW-1:0] clamp_lvl
);
  localparam logic [GW-1:0] UNITY = GW'(1) << GF;

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0 && !out_valid) |-> $stable(out_sample));

  assert_sync_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0 && (gain_act != $past(gain_act) || clamp_lvl != $past(clamp_lvl)))
      |-> $past(!sync_gate_en || blank_in));

  assert_level_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && {1'b0, in_sample} == clamp_lvl)
      |=> ##1 (out_valid && out_sample == $past(in_sample, 2)));

  assert_unity_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain_act == UNITY)
      |=> ##1 (out_valid && out_sample == $past(in_sample, 2)));
endmodule

bind clamp_gain_stage cgs_checker #(.DW(DW), .GW(GW), .GF(GF), .CLW(CW + CSH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .sync_gate_en(sync_gate_en), .blank_in(blank_in),
  .out_valid(out_valid), .out_sample(out_sample),
  .gain_act(gain_act), .clamp_lvl(clamp_lvl)
);

// File: tb/clamp_gain_stage_bench.sv
module clamp_gain_stage_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [9:0] in_sample = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sync_gate_en = 1'b0;
  logic       blank_in = 1'b0;
  logic       out_valid;
  logic [9:0] out_sample;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  int mg = 1024;
  int mc = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  clamp_gain_stage u_clamp_gain_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_gate_en(sync_gate_en), .blank_in(blank_in),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic int model(int s, int g, int code);
    int lvl = code * 16;
    int r = ((s - lvl) * g + 256) >>> 9;
    int y = r + lvl;
    if (y < 0) y = 0;
    if (y > 1023) y = 1023;
    return y;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) check("R4", 1, 0);
      else check(tag_q.pop_front(), out_sample, exp_q.pop_front());
    end
  end

  task automatic send(int s, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 10'(s);
    exp_q.push_back(model(s, mg, mc));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(int g, int code);
    wr(0, g & 255);
    wr(1, g >> 8);
    wr(2, code);
    idle(3);
    mg = g; mc = code;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and default gain 2.0
    check("R1", out_valid, 0);
    check("R1", out_sample, 0);
    send(100, "R1"); send(700, "R1 R3"); idle(4);

    // R4: two-clock latency
    @(negedge clk); in_valid = 1'b1; in_sample = 10'd5;
    exp_q.push_back(model(5, mg, mc)); tag_q.push_back("R4");
    @(negedge clk); in_valid = 1'b0; check("R4", out_valid, 0);
    @(negedge clk); check("R4", out_valid, 1);
    @(negedge clk); check("R4", out_valid, 0);

    // R5: low byte alone stages only
    wr(0, 8'h55); idle(3);
    send(100, "R5"); idle(3);
    // R6: high write commits {hi, staged lo}
    wr(1, 3); idle(3); mg = 12'h355;
    send(300, "R6"); idle(3);

    // R8: unity gain, nonzero clamp
    set_all(512, 9);
    for (int i = 0; i < 16; i++) send(i * 68, "R8");
    send(1023, "R8"); idle(3);

    // R7 with zero gain: output is the level
    set_all(0, 5);
    send(0, "R7"); send(1000, "R7"); idle(3);

    // R9: sample on the level for several gains
    for (int i = 0; i < 6; i++) begin
      set_all((i * 777 + 100) & 4095, 3 + 7 * i);
      send((3 + 7 * i) * 16, "R9");
      idle(3);
    end

    // R3: saturation at both ends
    set_all(4095, 0); send(1023, "R3"); send(300, "R3"); idle(3);
    set_all(4095, 4); send(0, "R3"); idle(3);
    set_all(4095, 100); send(0, "R3"); idle(3);

    // R2: exact halves round upward
    set_all(768, 0); send(1, "R2"); send(3, "R2"); idle(3);
    set_all(768, 1); send(15, "R2"); send(13, "R2"); idle(3);

    // R10: gated updates wait for blanking
    set_all(1024, 0);
    sync_gate_en = 1'b1;
    wr(0, 0); wr(1, 2); wr(2, 2); idle(3);
    send(300, "R10"); idle(3);
    @(negedge clk); blank_in = 1'b1;
    @(negedge clk); blank_in = 1'b0;
    mg = 512; mc = 2;
    send(300, "R10"); send(10, "R10"); idle(3);
    sync_gate_en = 1'b0;

    // R2: random mix
    for (int k = 0; k < 40; k++) begin
      set_all(int'($urandom_range(4095)), int'($urandom_range(127)));
      for (int j = 0; j < 12; j++) begin
        send(int'($urandom_range(1023)), "R2");
        if ($urandom_range(3) == 0) idle(1);
      end
      idle(3);
    end

    idle(4);
    check("R4", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule